// File: doc/BRIEF.md
# Serial Code-Group Aligner

This block takes a serial receive bit stream that has no known group boundary and cuts it into 5-bit code-groups. It finds the boundary by looking for the 10-bit start-of-stream delimiter (the J group followed by the K group) in the most recent ten bits. Until that delimiter appears, the block produces no groups. When the delimiter appears, the block locks its group boundary to it and passes the delimiter on as two groups, so that a downstream code-group decoder sees the start of the stream. Every later group is taken on that same boundary.

The serial bit comes from one of two sources. One is the descrambler output. The other is a bypass path that comes straight from the line decoder. A static select input chooses between them. A per-bit qualifier marks the cycles that carry a new bit, so the bit rate can be slower than the clock. The lock is released when two idle groups in a row arrive on the locked boundary. The block then hunts for the next delimiter.

Top module: `cg_aligner`

## Requirements
- R1: When `use_bypass` is 1, the serial bit is taken from `line_bit`; when it is 0, it is taken from `dscr_bit`. The source that is not selected has no effect on the outputs.
- R2: Within each group, the first bit received is the most significant bit of `grp_data` (bit 4), and the fifth bit received is bit 0.
- R3: While not locked, `grp_valid` stays low, with one exception: the J group is emitted on the cycle in which the delimiter is detected.
- R4: Lock is reached when the last ten qualified bits, oldest first, equal 1100010001. `aligned` reads 1 in the cycle that follows the clock edge on which the last K bit is taken.
- R5: On detection, the block emits J (11000) on the detection cycle. It emits K (10001) on the next clock cycle, whether or not that cycle carries a bit.
- R6: After K, a group is emitted on every fifth qualified bit, counted from the bit that follows the delimiter. A J/K pattern that appears off that boundary while locked does not move the boundary.
- R7: In cycles where `bit_en` is 0, no bit is shifted in and no bit is counted. The bit inputs are ignored in those cycles.
- R8: Lock is released after two consecutive locked groups equal to the idle code 11111. The second idle group is still emitted, and `aligned` falls on the same edge. A non-idle group between two idle groups restarts the count.
- R9: After a release, the delimiter search is armed again. A new delimiter at any bit offset sets up a new boundary.
- R10: Synchronous active-high `rst` clears `aligned`, `grp_valid` and `grp_data` to 0 and returns the block to hunting.
- R11: `grp_valid` is a one-cycle strobe per group. `grp_data` holds its value when no group is emitted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | Marks a cycle that carries a new serial bit |
| use_bypass | input | 1 | 1 selects `line_bit`, 0 selects `dscr_bit` |
| dscr_bit | input | 1 | Serial bit from the descrambler |
| line_bit | input | 1 | Serial bit straight from the line decoder |
| grp_data | output | 5 | Aligned code-group, first-received bit in bit 4 |
| grp_valid | output | 1 | One-cycle strobe for a new group |
| aligned | output | 1 | Group boundary is locked |

## Verification
Two situations are hard to reach from the ports. The first is a delimiter bit pattern that shows up inside locked payload but off the group boundary. The second is a long pause in `bit_en` in the middle of a group. For the first, the stimulus splices the ten delimiter bits two positions into the payload, so that they straddle three locked groups. The bench then checks that those three groups come out unchanged. For the second, the bench stops the bit strobe after three bits of a group and toggles both bit sources for many cycles. It then finishes the group and checks that the group matches the bits given before and after the pause. The stimulus table also runs delimiters at several bit offsets, with and without idle cycles between bits. It inverts the bit source that is not selected, so that a wrong select shows up as inverted groups.

// File: rtl/cga_pkg.sv
package cga_pkg;
  // Framer phases: hunting for the delimiter, one cycle to pass on K, locked.
  typedef enum logic [1:0] {
    PH_HUNT   = 2'd0,
    PH_SEND_K = 2'd1,
    PH_LOCKED = 2'd2
  } cga_phase_e;
endpackage

// File: rtl/cga_shift.sv
// Source select and serial history window. win_nxt is the window as it
// will be once the current qualified bit has been taken.
module cga_shift #(
  parameter int WIN_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bit_en,
  input  logic             use_bypass,
  input  logic             dscr_bit,
  input  logic             line_bit,
  output logic [WIN_W-1:0] win_nxt
);
  logic             sel_bit;
  logic [WIN_W-1:0] win_q;

  assign sel_bit = use_bypass ? line_bit : dscr_bit;
  // newest bit enters at the LSB, so the oldest bit sits at the MSB
  assign win_nxt = {win_q[WIN_W-2:0], sel_bit};

  always_ff @(posedge clk) begin
    if (rst) begin
      win_q <= '0;
    end else if (bit_en) begin
      win_q <= win_nxt;
    end
  end
endmodule

// File: rtl/cga_match.sv
// Compares the full history window against the delimiter pattern.
module cga_match #(
  parameter int                WIN_W   = 10,
  parameter logic [WIN_W-1:0]  PATTERN = 10'b1100010001
) (
  input  logic [WIN_W-1:0] win,
  output logic             hit
);
  logic [WIN_W-1:0] diff;

  for (genvar i = 0; i < WIN_W; i++) begin : g_bit
    assign diff[i] = win[i] ^ PATTERN[i];
  end

  assign hit = (diff == '0);
endmodule

// File: rtl/cga_framer.sv
// Boundary counter, lock control and registered group outputs.
module cga_framer
  import cga_pkg::*;
#(
  parameter int                  GRP_W     = 5,
  parameter int                  IDLE_RUN  = 2,
  parameter logic [GRP_W-1:0]    IDLE_CODE = 5'b11111,
  localparam int                 WIN_W     = 2 * GRP_W,
  localparam int                 CNT_W     = (GRP_W > 1) ? $clog2(GRP_W) : 1,
  localparam int                 IDL_W     = $clog2(IDLE_RUN + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  input  logic             hit,
  input  logic [WIN_W-1:0] win_nxt,
  output logic [GRP_W-1:0] grp_data,
  output logic             grp_valid,
  output logic             aligned
);
  localparam logic [CNT_W-1:0] CNT_LAST  = CNT_W'(GRP_W - 1);
  localparam logic [IDL_W-1:0] IDLE_LAST = IDL_W'(IDLE_RUN - 1);

  cga_phase_e       phase;
  logic [CNT_W-1:0] bit_cnt;
  logic [IDL_W-1:0] idle_cnt;
  logic [GRP_W-1:0] k_hold;
  logic [GRP_W-1:0] new_grp;

  assign new_grp = win_nxt[GRP_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= PH_HUNT;
      bit_cnt   <= '0;
      idle_cnt  <= '0;
      k_hold    <= '0;
      grp_data  <= '0;
      grp_valid <= 1'b0;
      aligned   <= 1'b0;
    end else begin
      grp_valid <= 1'b0;
      unique case (phase)
        PH_HUNT: begin
          if (step && hit) begin
            grp_data  <= win_nxt[WIN_W-1:GRP_W];
            grp_valid <= 1'b1;
            k_hold    <= win_nxt[GRP_W-1:0];
            aligned   <= 1'b1;
            bit_cnt   <= '0;
            idle_cnt  <= '0;
            phase     <= PH_SEND_K;
          end
        end
        PH_SEND_K: begin
          grp_data  <= k_hold;
          grp_valid <= 1'b1;
          phase     <= PH_LOCKED;
          if (step) begin
            bit_cnt <= CNT_W'(1);
          end
        end
        PH_LOCKED: begin
          if (step) begin
            if (bit_cnt == CNT_LAST) begin
              bit_cnt   <= '0;
              grp_data  <= new_grp;
              grp_valid <= 1'b1;
              if (new_grp == IDLE_CODE) begin
                if (idle_cnt == IDLE_LAST) begin
                  idle_cnt <= '0;
                  aligned  <= 1'b0;
                  phase    <= PH_HUNT;
                end else begin
                  idle_cnt <= idle_cnt + IDL_W'(1);
                end
              end else begin
                idle_cnt <= '0;
              end
            end else begin
              bit_cnt <= bit_cnt + CNT_W'(1);
            end
          end
        end
        default: phase <= PH_HUNT;
      endcase
    end
  end
endmodule

// File: rtl/cg_aligner.sv
module cg_aligner #(
  parameter int                      GRP_W      = 5,
  parameter int                      IDLE_RUN   = 2,
  parameter logic [2*GRP_W-1:0]      JK_PATTERN = 10'b1100010001,
  parameter logic [GRP_W-1:0]        IDLE_CODE  = 5'b11111
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bit_en,
  input  logic             use_bypass,
  input  logic             dscr_bit,
  input  logic             line_bit,
  output logic [GRP_W-1:0] grp_data,
  output logic             grp_valid,
  output logic             aligned
);
  localparam int WIN_W = 2 * GRP_W;

  logic [WIN_W-1:0] win_nxt;
  logic             jk_hit;

  cga_shift #(.WIN_W(WIN_W)) u_shift (
    .clk        (clk),
    .rst        (rst),
    .bit_en     (bit_en),
    .use_bypass (use_bypass),
    .dscr_bit   (dscr_bit),
    .line_bit   (line_bit),
    .win_nxt    (win_nxt)
  );

  cga_match #(.WIN_W(WIN_W), .PATTERN(JK_PATTERN)) u_match (
    .win (win_nxt),
    .hit (jk_hit)
  );

  cga_framer #(
    .GRP_W     (GRP_W),
    .IDLE_RUN  (IDLE_RUN),
    .IDLE_CODE (IDLE_CODE)
  ) u_framer (
    .clk       (clk),
    .rst       (rst),
    .step      (bit_en),
    .hit       (jk_hit),
    .win_nxt   (win_nxt),
    .grp_data  (grp_data),
    .grp_valid (grp_valid),
    .aligned   (aligned)
  );
endmodule

// File: rtl/cga_checker.sv
module cga_checker #(
  parameter int                 GRP_W      = 5,
  parameter logic [2*GRP_W-1:0] JK_PATTERN = 10'b1100010001,
  parameter logic [GRP_W-1:0]   IDLE_CODE  = 5'b11111
) (
  input logic             clk,
  input logic             rst,
  input logic             bit_en,
  input logic [GRP_W-1:0] grp_data,
  input logic             grp_valid,
  input logic             aligned
);
  localparam logic [GRP_W-1:0] J_GRP = JK_PATTERN[2*GRP_W-1:GRP_W];
  localparam logic [GRP_W-1:0] K_GRP = JK_PATTERN[GRP_W-1:0];

  // R3
  strobe_in_lock_chk: assert property (@(posedge clk) disable iff (rst)
    grp_valid |-> (aligned || $past(aligned)));

  // R5
  j_on_lock_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(aligned) |-> (grp_valid && grp_data == J_GRP));

  // R5
  k_after_j_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(aligned) |=> (grp_valid && grp_data == K_GRP));

  // R7
  gated_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !bit_en |=> $stable(aligned));

  // R8
  idle_release_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(aligned) |-> (grp_valid && grp_data == IDLE_CODE));

  // R11
  data_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !grp_valid |-> $stable(grp_data));

  // R11
  single_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    grp_valid |=> (!grp_valid || grp_data == K_GRP));
endmodule

bind cg_aligner cga_checker #(
  .GRP_W      (GRP_W),
  .JK_PATTERN (JK_PATTERN),
  .IDLE_CODE  (IDLE_CODE)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bit_en    (bit_en),
  .grp_data  (grp_data),
  .grp_valid (grp_valid),
  .aligned   (aligned)
);

// File: tb/sim_cg_aligner.sv
module sim_cg_aligner;
  localparam logic [4:0] J_G = 5'b11000;
  localparam logic [4:0] K_G = 5'b10001;

  // {bypass, gap, pre_ones[2:0], exp_count[3:0], payload 6x5 (first group in MSBs)}
  localparam int NVEC = 4;
  localparam logic [38:0] VEC [NVEC] = '{
    {1'b0, 1'b0, 3'd0, 4'd8, 5'b01110, 5'b10100, 5'b01011, 5'b01001, 5'b11111, 5'b11111},
    {1'b1, 1'b0, 3'd3, 4'd8, 5'b11111, 5'b01010, 5'b11111, 5'b10010, 5'b11111, 5'b11111},
    {1'b0, 1'b1, 3'd1, 4'd8, 5'b00110, 5'b00100, 5'b01000, 5'b01010, 5'b11111, 5'b11111},
    {1'b1, 1'b1, 3'd4, 4'd8, 5'b10011, 5'b11100, 5'b00001, 5'b10110, 5'b11111, 5'b11111}
  };

  logic clk = 1'b0;
  logic rst, bit_en, use_bypass, dscr_bit, line_bit;
  logic [4:0] grp_data;
  logic grp_valid, aligned;

  int checks = 0;
  int fails  = 0;
  int log_n  = 0;
  logic [4:0] log_d [0:63];

  always #2 clk = ~clk;

  cg_aligner u0 (
    .clk(clk), .rst(rst), .bit_en(bit_en), .use_bypass(use_bypass),
    .dscr_bit(dscr_bit), .line_bit(line_bit),
    .grp_data(grp_data), .grp_valid(grp_valid), .aligned(aligned)
  );

  always @(negedge clk) begin
    if (!rst && grp_valid) begin
      if (log_n < 64) log_d[log_n] = grp_data;
      log_n++;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic b, input bit gap);
    @(negedge clk);
    bit_en = 1'b1;
    if (use_bypass) begin line_bit = b; dscr_bit = ~b; end
    else begin dscr_bit = b; line_bit = ~b; end
    @(negedge clk);
    bit_en = 1'b0;
    if (gap) begin
      dscr_bit = ~dscr_bit;
      line_bit = ~line_bit;
      @(negedge clk);
    end
  endtask

  task automatic send_grp(input logic [4:0] g, input bit gap);
    for (int i = 4; i >= 0; i--) send_bit(g[i], gap);
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired, run hung actual=1 expected=0");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int base;
    logic [38:0] v;
    rst = 1'b1; bit_en = 1'b0; use_bypass = 1'b0; dscr_bit = 1'b0; line_bit = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10: reset state
    chk(aligned == 1'b0, "R10 aligned after reset", aligned, 0);
    chk(grp_valid == 1'b0, "R10 grp_valid after reset", grp_valid, 0);
    chk(grp_data == 5'd0, "R10 grp_data after reset", grp_data, 0);

    // R3: no delimiter, no strobes
    base = log_n;
    for (int i = 0; i < 20; i++) send_bit(i[0], 1'b0);
    for (int i = 0; i < 20; i++) send_bit(1'b1, 1'b0);
    settle();
    chk(log_n - base == 0, "R3 strobes while hunting", log_n - base, 0);
    chk(aligned == 1'b0, "R3 aligned while hunting", aligned, 0);

    // table walk: R1 R2 R4 R5 R6 R8 R9
    for (int n = 0; n < NVEC; n++) begin
      v = VEC[n];
      @(negedge clk);
      use_bypass = v[38];
      base = log_n;
      for (int p = 0; p < int'(v[36:34]); p++) send_bit(1'b1, v[37]);
      send_grp(J_G, v[37]);
      send_grp(K_G, v[37]);
      chk(aligned == 1'b1, "R4 aligned after delimiter", aligned, 1);
      for (int g = 0; g < 6; g++) begin
        send_grp(v[29-5*g -: 5], v[37]);
        if (g == 4) chk(aligned == 1'b1, "R8 still locked after one idle", aligned, 1);
      end
      chk(aligned == 1'b0, "R8 released after two idles", aligned, 0);
      for (int t = 0; t < 7; t++) send_bit(1'b1, v[37]);
      settle();
      chk(log_n - base == int'(v[33:30]), "R9 R6 group count per vector", log_n - base, int'(v[33:30]));
      chk(log_d[base] == J_G, "R5 first group is J", log_d[base], J_G);
      chk(log_d[base+1] == K_G, "R5 second group is K", log_d[base+1], K_G);
      for (int g = 0; g < 6; g++)
        chk(log_d[base+2+g] == v[29-5*g -: 5], "R1 R2 R6 payload group",
            log_d[base+2+g], v[29-5*g -: 5]);
    end

    // R7: pause mid-group with toggling sources
    @(negedge clk);
    use_bypass = 1'b0;
    base = log_n;
    send_bit(1'b1, 1'b0); send_bit(1'b1, 1'b0);
    send_grp(J_G, 1'b0); send_grp(K_G, 1'b0);
    send_bit(1'b1, 1'b0); send_bit(1'b0, 1'b0); send_bit(1'b1, 1'b0);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      dscr_bit = ~dscr_bit;
      line_bit = ~line_bit;
    end
    chk(aligned == 1'b1, "R7 lock held while gated", aligned, 1);
    chk(log_n - base == 2, "R7 no group while gated", log_n - base, 2);
    send_bit(1'b1, 1'b0); send_bit(1'b0, 1'b0);
    settle();
    chk(log_n - base == 3, "R7 group after pause", log_n - base, 3);
    chk(log_d[base+2] == 5'b10110, "R7 group content across pause", log_d[base+2], 5'b10110);
    for (int i = 0; i < 10; i++) send_bit(1'b1, 1'b0);
    chk(aligned == 1'b0, "R8 release after pause test", aligned, 0);

    // R10: reset while locked
    send_grp(J_G, 1'b0); send_grp(K_G, 1'b0);
    send_bit(1'b0, 1'b0); send_bit(1'b1, 1'b0);
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(aligned == 1'b0, "R10 aligned after mid reset", aligned, 0);
    chk(grp_valid == 1'b0, "R10 grp_valid after mid reset", grp_valid, 0);
    chk(grp_data == 5'd0, "R10 grp_data after mid reset", grp_data, 0);
    base = log_n;
    send_grp(5'b01010, 1'b0); send_grp(5'b01010, 1'b0);
    settle();
    chk(log_n - base == 0, "R10 R3 hunting after mid reset", log_n - base, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule